// File: doc/BRIEF.md
# Convert-Start and Power-Down Sequencer

This block is the digital control core of a sampling converter model. It runs on a system clock and watches a single active-low convert-start input. A falling edge of that input places the sampler in hold and starts a fixed conversion sequence. A cycle timer ends the hold window, raises a one-clock end-of-conversion pulse that captures the result word, and then reaches a later decision point. At that point the level of the same input chooses between staying powered for the next conversion (high-speed use) and dropping into the low-current state (automatic power-down).

A rising edge on the input wakes the block from power-down. The wake-up lasts one of two cycle counts, chosen by a static reference-select input. With the external reference, a falling edge that arrives during wake-up is remembered, and its conversion starts as soon as wake-up ends. With the internal reference, such an edge is discarded. Analog behaviour is not modelled. The converted value is taken from a stimulus input at the end-of-conversion pulse.

Top module: `cs_pd_seq`

## Requirements
- R1: While reset is asserted and on release, `pdown_o` is 1, `hold_o`, `busy_o` and `eoc_o` are 0, and `result_o` is 0.
- R2: In power-down, a rising edge of `conv_start_n` starts a wake-up of PUP_EXT_CYC cycles when `ref_internal` is 0, or PUP_INT_CYC cycles when it is 1. `pdown_o` goes to 0 on the clock that detects the edge, and the block is ready when the wake-up ends.
- R3: A falling edge while ready starts a sequence on the next clock. `busy_o` stays 1 for SAMPLE_CYC cycles, and `hold_o` stays 1 for the first HOLD_CYC of those cycles only.
- R4: `eoc_o` is a one-clock pulse in sequence cycle CONV_CYC, where the first busy cycle is cycle 1. `result_o` takes the value of `result_in` present during that cycle and shows it from the next clock.
- R5: In the last busy cycle the level of `conv_start_n` is sampled. If it is 0 the block enters power-down (`pdown_o`=1). If it is 1 the block stays ready, and the next falling edge converts at once.
- R6: A falling edge that arrives while `busy_o` is 1 neither restarts nor extends the sequence.
- R7: With `ref_internal`=0, a falling edge during wake-up is held, and its sequence begins on the clock after wake-up completes.
- R8: With `ref_internal`=1, a falling edge during wake-up is discarded. The block becomes ready without converting.
- R9: A rising edge during wake-up or during a sequence changes neither the power state nor the sequence timing, and `busy_o` is never 1 while `pdown_o` is 1.
- R10: `result_o` changes only on the clock after an `eoc_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Active-low convert-start and power-control input |
| ref_internal | input | 1 | Static reference select: 1 internal (long wake-up), 0 external |
| result_in | input | RES_W | Conversion value supplied by stimulus |
| hold_o | output | 1 | 1 = sampler in hold, 0 = track |
| busy_o | output | 1 | Conversion sequence in progress |
| eoc_o | output | 1 | One-clock end-of-conversion pulse |
| pdown_o | output | 1 | Block is in the low-current powered-down state |
| result_o | output | RES_W | Result register read by the serial port |

## Verification
The bound checker watches local rules on every cycle. Hold only ever appears inside busy and opens together with it. The end-of-conversion pulse lasts a single clock and falls within busy. The result register moves only after that pulse. Leaving busy lands in power-down or ready according to the sampled input level, and a wake-up only follows a high input level. Exact window lengths, the pending conversion held across an external-reference wake-up, the discarded edge with the internal reference, and the ignored mid-sequence edge are shown only by the bench. It runs its behavioural model against the outputs on every clock through those scenarios.

// File: rtl/cs_pd_pkg.sv
package cs_pd_pkg;

   typedef enum logic [1:0] {
      ST_DOWN   = 2'd0,
      ST_WAKE   = 2'd1,
      ST_READY  = 2'd2,
      ST_ACTIVE = 2'd3
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/cs_edge_det.sv
module cs_edge_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic lvl_n,
   output logic fall,
   output logic rise
);

   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_n = pin_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2+((SYNC_STAGES==1)?1:0):0], pin_n};
         end
         assign lvl_n = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl_n;
   end

   assign fall = prev_q & ~lvl_n;
   assign rise = ~prev_q & lvl_n;

endmodule

// File: rtl/cs_pup_timer.sv
module cs_pup_timer #(
   parameter int PUP_EXT_CYC = 125,
   parameter int PUP_INT_CYC = 3125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sel_int,
   output logic done
);

   localparam int MAX_CYC = (PUP_EXT_CYC > PUP_INT_CYC) ? PUP_EXT_CYC : PUP_INT_CYC;
   localparam int CW      = cs_pd_pkg::cnt_width(MAX_CYC);

   logic          run_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_q;
   logic [CW-1:0] lim_sel;

   generate
      if (PUP_EXT_CYC == PUP_INT_CYC) begin : g_one_len
         assign lim_sel = CW'(PUP_EXT_CYC - 1);
      end else begin : g_two_len
         assign lim_sel = sel_int ? CW'(PUP_INT_CYC - 1) : CW'(PUP_EXT_CYC - 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         lim_q <= '0;
      end else if (start && !run_q) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         lim_q <= lim_sel;
      end else if (run_q) begin
         if (cnt_q == lim_q) run_q <= 1'b0;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = run_q && (cnt_q == lim_q);

endmodule

// File: rtl/cs_conv_timer.sv
module cs_conv_timer #(
   parameter int HOLD_CYC   = 15,
   parameter int CONV_CYC   = 53,
   parameter int SAMPLE_CYC = 66
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic hold,
   output logic busy,
   output logic eoc,
   output logic smp_pt
);

   localparam int CW = cs_pd_pkg::cnt_width(SAMPLE_CYC);

   logic          act_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (start && !act_q) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (act_q) begin
         if (cnt_q == CW'(SAMPLE_CYC - 1)) act_q <= 1'b0;
         else                              cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy   = act_q;
   assign hold   = act_q && (cnt_q < CW'(HOLD_CYC));
   assign eoc    = act_q && (cnt_q == CW'(CONV_CYC - 1));
   assign smp_pt = act_q && (cnt_q == CW'(SAMPLE_CYC - 1));

endmodule

// File: rtl/cs_pd_seq.sv
module cs_pd_seq
   import cs_pd_pkg::*;
#(
   parameter int RES_W       = 8,
   parameter int HOLD_CYC    = 15,
   parameter int CONV_CYC    = 53,
   parameter int SAMPLE_CYC  = 66,
   parameter int PUP_EXT_CYC = 125,
   parameter int PUP_INT_CYC = 3125,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_start_n,
   input  logic             ref_internal,
   input  logic [RES_W-1:0] result_in,
   output logic             hold_o,
   output logic             busy_o,
   output logic             eoc_o,
   output logic             pdown_o,
   output logic [RES_W-1:0] result_o
);

   generate
      if (!(HOLD_CYC > 0 && HOLD_CYC < CONV_CYC && CONV_CYC < SAMPLE_CYC)) begin : g_bad_seq
         $error("sequence lengths must satisfy 0 < HOLD_CYC < CONV_CYC < SAMPLE_CYC");
      end
      if (PUP_EXT_CYC < 1 || PUP_INT_CYC < 1) begin : g_bad_pup
         $error("wake-up lengths must be at least one cycle");
      end
      if (SYNC_STAGES < 0 || RES_W < 1) begin : g_bad_misc
         $error("SYNC_STAGES must be non-negative and RES_W positive");
      end
   endgenerate

   logic       cs_lvl_n, cs_fall, cs_rise;
   logic       pup_start, pup_done;
   logic       conv_go, smp_pt;
   logic       arm, pend_now, pend_q;
   seq_state_t state_q, state_d;
   logic [RES_W-1:0] res_q;

   cs_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (conv_start_n),
      .lvl_n (cs_lvl_n),
      .fall  (cs_fall),
      .rise  (cs_rise)
   );

   cs_pup_timer #(.PUP_EXT_CYC(PUP_EXT_CYC), .PUP_INT_CYC(PUP_INT_CYC)) u_pup (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (pup_start),
      .sel_int (ref_internal),
      .done    (pup_done)
   );

   cs_conv_timer #(.HOLD_CYC(HOLD_CYC), .CONV_CYC(CONV_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_conv (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (conv_go),
      .hold   (hold_o),
      .busy   (busy_o),
      .eoc    (eoc_o),
      .smp_pt (smp_pt)
   );

   // wake-up request and deferred-start bookkeeping
   assign pup_start = (state_q == ST_DOWN) && cs_rise;
   assign arm       = (state_q == ST_WAKE) && cs_fall && !ref_internal;
   assign pend_now  = pend_q | arm;
   assign conv_go   = ((state_q == ST_READY) && cs_fall) ||
                      ((state_q == ST_WAKE) && pup_done && pend_now);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_DOWN:   if (cs_rise)  state_d = ST_WAKE;
         ST_WAKE:   if (pup_done) state_d = pend_now ? ST_ACTIVE : ST_READY;
         ST_READY:  if (cs_fall)  state_d = ST_ACTIVE;
         ST_ACTIVE: if (smp_pt)   state_d = cs_lvl_n ? ST_READY : ST_DOWN;
         default:                 state_d = ST_DOWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DOWN;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_WAKE || pup_done) pend_q <= 1'b0;
         else if (arm)                       pend_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     res_q <= '0;
      else if (eoc_o) res_q <= result_in;
   end

   assign pdown_o  = (state_q == ST_DOWN);
   assign result_o = res_q;

endmodule

// File: rtl/cs_pd_seq_chk.sv
module cs_pd_seq_chk #(
   parameter int RES_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_lvl_n,
   input logic             hold_o,
   input logic             busy_o,
   input logic             eoc_o,
   input logic             pdown_o,
   input logic [RES_W-1:0] result_o
);

   p_hold_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |-> busy_o);

   p_start_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> hold_o);

   p_eoc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |=> !eoc_o);

   p_eoc_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> (busy_o && !hold_o));

   p_down_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && !$past(cs_lvl_n)) |-> pdown_o);

   p_stay_on_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && $past(cs_lvl_n)) |-> !pdown_o);

   p_wake_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdown_o) |-> $past(cs_lvl_n));

   p_idle_when_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pdown_o |-> !busy_o);

   p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eoc_o) |-> $stable(result_o));

endmodule

bind cs_pd_seq cs_pd_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_lvl_n (cs_lvl_n),
   .hold_o   (hold_o),
   .busy_o   (busy_o),
   .eoc_o    (eoc_o),
   .pdown_o  (pdown_o),
   .result_o (result_o)
);

// File: tb/cs_pd_seq_tb.sv
module cs_pd_seq_tb;

   localparam int RW   = 8;
   localparam int HOLD = 3;
   localparam int CONV = 8;
   localparam int SMP  = 11;
   localparam int PEXT = 6;
   localparam int PINT = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          ref_int = 1'b0;
   logic [RW-1:0] rin = 8'h11;
   logic          hold, busy, eoc, pdown;
   logic [RW-1:0] res;

   int n_chk = 0;
   int n_bad = 0;
   int busy_cnt = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   cs_pd_seq #(
      .RES_W(RW), .HOLD_CYC(HOLD), .CONV_CYC(CONV), .SAMPLE_CYC(SMP),
      .PUP_EXT_CYC(PEXT), .PUP_INT_CYC(PINT), .SYNC_STAGES(0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .conv_start_n(cs_n), .ref_internal(ref_int),
      .result_in(rin), .hold_o(hold), .busy_o(busy), .eoc_o(eoc),
      .pdown_o(pdown), .result_o(res)
   );

   // behavioural reference: 0 down, 1 waking, 2 ready, 3 converting
   int            m_st = 0;
   int            m_cnt = 0;
   int            m_wait = 0;
   int            m_lim = 0;
   bit            m_pend = 0;
   bit            m_prev = 1;
   logic [RW-1:0] m_res = '0;

   always @(posedge clk) begin
      bit f, r;
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_prev = 1; m_res = '0; m_pend = 0;
      end else begin
         f = m_prev && !cs_n;
         r = !m_prev && cs_n;
         case (m_st)
            0: if (r) begin m_st = 1; m_wait = 0; m_pend = 0; m_lim = ref_int ? PINT : PEXT; end
            1: begin
               if (f && !ref_int) m_pend = 1;
               if (m_wait == m_lim - 1) begin
                  m_st = m_pend ? 3 : 2; m_cnt = 0; m_pend = 0;
               end else m_wait++;
            end
            2: if (f) begin m_st = 3; m_cnt = 0; end
            default: begin
               if (m_cnt == CONV - 1) m_res = rin;
               if (m_cnt == SMP - 1) m_st = cs_n ? 2 : 0;
               else m_cnt++;
            end
         endcase
         m_prev = cs_n;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(hold  === (m_st == 3 && m_cnt < HOLD),      "R3/R6 hold_o", hold, (m_st == 3 && m_cnt < HOLD));
         check(busy  === (m_st == 3),                      "R3/R7/R8 busy_o", busy, (m_st == 3));
         check(eoc   === (m_st == 3 && m_cnt == CONV - 1), "R4 eoc_o", eoc, (m_st == 3 && m_cnt == CONV - 1));
         check(pdown === (m_st == 0),                      "R2/R5/R9 pdown_o", pdown, (m_st == 0));
         check(res   === m_res,                            "R4/R10 result_o", res, m_res);
         if (busy === 1'b1) busy_cnt++;
         rin = rin + 8'd37;
      end
   endtask

   initial begin : watchdog
      wait (cyc > 50000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [RW-1:0] kept;
      step(3);
      // R1: reset values while reset held
      check(pdown === 1'b1 && busy === 1'b0 && hold === 1'b0 && eoc === 1'b0 && res === '0,
            "R1 reset state", {pdown, busy, hold, eoc}, 4'b1000);
      rst_n = 1'b1;
      step(2);
      check(pdown === 1'b1, "R1 down after release", pdown, 1);

      // R2: wake with external reference, then convert and power down (low at sample)
      cs_n = 1'b0; step(2);
      cs_n = 1'b1; step(1);
      check(pdown === 1'b0, "R2 wake leaves power-down", pdown, 0);
      step(8);
      busy_cnt = 0;
      cs_n = 1'b0; step(SMP + 3);
      check(busy_cnt == SMP, "R3 busy length", busy_cnt, SMP);
      check(pdown === 1'b1, "R5 low at sample powers down", pdown, 1);

      // R7: early falling edge during external wake is held; rise mid-wake ignored (R9)
      busy_cnt = 0;
      cs_n = 1'b1; step(2);
      cs_n = 1'b0; step(2);
      cs_n = 1'b1; step(PEXT + SMP + 2);
      check(busy_cnt == SMP, "R7 deferred conversion ran", busy_cnt, SMP);
      check(pdown === 1'b0, "R5 high at sample stays powered", pdown, 0);

      // R6: second falling edge mid-sequence ignored; rise mid-sequence (R9)
      busy_cnt = 0;
      cs_n = 1'b0; step(4);
      cs_n = 1'b1; step(2);
      cs_n = 1'b0; step(2);
      cs_n = 1'b1; step(12);
      check(busy_cnt == SMP, "R6 no restart", busy_cnt, SMP);
      check(pdown === 1'b0 && busy === 1'b0, "R9 power state kept", pdown, 0);

      // R5: back-to-back high-speed conversions with changing results
      for (int k = 0; k < 3; k++) begin
         cs_n = 1'b0; step(1);
         cs_n = 1'b1; step(SMP + 1);
      end
      kept = res;
      step(6);
      check(res === kept, "R10 result held between pulses", res, kept);

      // R8: internal reference discards early edge
      cs_n = 1'b0; step(SMP + 2);
      check(pdown === 1'b1, "R5 powered down before internal wake", pdown, 1);
      ref_int = 1'b1;
      busy_cnt = 0;
      cs_n = 1'b1; step(3);
      cs_n = 1'b0; step(1);
      cs_n = 1'b1; step(PINT + 4);
      check(busy_cnt == 0, "R8 early edge dropped", busy_cnt, 0);
      check(pdown === 1'b0, "R2 internal wake done", pdown, 0);
      cs_n = 1'b0; step(SMP + 3);
      check(busy_cnt == SMP, "R3 converts after internal wake", busy_cnt, SMP);
      check(pdown === 1'b1, "R5 down again", pdown, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule